// File: doc/BRIEF.md
# Byte/Pair Register File

This block is the working-register store of a single-issue 8-bit datapath. It holds 32 byte-wide registers and gives two combinational byte read ports and one byte write port. An even/odd pair of registers can also be treated as one 16-bit word, so a 16-bit operand can be read and a 16-bit result can be stored in a single cycle.

A pair is selected by a 4-bit pair index p. It covers register 2p, which holds the low byte, and register 2p+1, which holds the high byte. Writes take effect on the rising clock edge. All reads are combinational. A reset is synchronous and active-high, and it clears every register.

The surrounding datapath uses the read and write ports in four combinations:
- one byte operand with a byte result;
- two byte operands with a byte result;
- two byte operands with a pair result;
- one pair operand with a pair result.

Top module: `regfile_pair`

## Requirements
- R1: While `rst` is high at a rising clock edge, all 32 registers become 0x00.
- R2: `rda_data` always equals register `rda_addr`, and `rdb_data` always equals register `rdb_addr`. Both are combinational, and the two ports are independent.
- R3: When `wr_en` is high at a rising edge, register `wr_addr` takes `wr_data`.
- R4: A read of a register that is being written in the same cycle returns the value the register held before the edge.
- R5: When `pw_en` is high at a rising edge, register 2*`pw_idx` takes `pw_data[7:0]` and register 2*`pw_idx`+1 takes `pw_data[15:8]`.
- R6: `rp_data` always equals {register 2*`rp_idx`+1, register 2*`rp_idx`}, combinationally.
- R7: A pair write may occur in the same cycle as two byte reads or a pair read. Those reads show the contents from before the edge.
- R8: If `wr_en` and `pw_en` are both high, the pair write wins on both registers of its pair. A byte write aimed outside that pair still takes effect.
- R9: At an edge with `rst`, `wr_en` and `pw_en` all low, no register changes, whatever the address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 5 | Byte write register number |
| wr_data | input | 8 | Byte write data |
| pw_en | input | 1 | Pair write enable |
| pw_idx | input | 4 | Pair write index (registers 2p, 2p+1) |
| pw_data | input | 16 | Pair write data, low byte to even register |
| rda_addr | input | 5 | Read port A register number |
| rda_data | output | 8 | Read port A data |
| rdb_addr | input | 5 | Read port B register number |
| rdb_data | output | 8 | Read port B data |
| rp_idx | input | 4 | Pair read index |
| rp_data | output | 16 | Pair read data {odd, even} |

## Verification
Every register is loaded with a distinct value computed from its number. Both byte read ports are then swept over all 32x32 address combinations, which separates crossed or stuck address bits on either port. Each of the 16 pairs is written with a 16-bit value whose two halves differ and is read back both bytewise and as a pair. This exposes swapped halves and misaligned pair indexing. Separate cycles drive reads that coincide with writes, byte and pair writes that collide or do not overlap, idle cycles with busy address and data lines, and a late reset. These cycles separate the old-value read rule, the pair-wins priority, write-enable leakage and the reset clear.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Number of the even register that opens a pair.
  function automatic int unsigned pair_lo(input int unsigned idx);
    return idx * 2;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int NREG = 32,
  parameter int W    = 8,
  localparam int AW  = $clog2(NREG),
  localparam int PW  = AW - 1
) (
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [W-1:0]           wr_data,
  input  logic                   pw_en,
  input  logic [PW-1:0]          pw_idx,
  input  logic [2*W-1:0]         pw_data,
  output logic [NREG-1:0]        we,
  output logic [NREG-1:0][W-1:0] wd
);
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [AW-1:0] IA = AW'(i);
    logic pair_hit;
    assign pair_hit = pw_en && (IA[AW-1:1] == pw_idx);
    always_comb begin
      if (pair_hit) begin
        we[i] = 1'b1;
        wd[i] = IA[0] ? pw_data[2*W-1:W] : pw_data[W-1:0];
      end else if (wr_en && (wr_addr == IA)) begin
        we[i] = 1'b1;
        wd[i] = wr_data;
      end else begin
        we[i] = 1'b0;
        wd[i] = wr_data;
      end
    end
  end
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int NREG = 32,
  parameter int W    = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [NREG-1:0][W-1:0] mem,
  input  logic [AW-1:0]          addr,
  output logic [W-1:0]           data
);
  assign data = mem[addr];
endmodule

// File: rtl/rf_pair_mux.sv
module rf_pair_mux #(
  parameter int NREG = 32,
  parameter int W    = 8,
  localparam int AW  = $clog2(NREG),
  localparam int PW  = AW - 1
) (
  input  logic [NREG-1:0][W-1:0] mem,
  input  logic [PW-1:0]          idx,
  output logic [2*W-1:0]         data
);
  logic [NREG/2-1:0][2*W-1:0] pairs;
  for (genvar p = 0; p < NREG / 2; p++) begin : g_pair
    assign pairs[p] = {mem[rf_pkg::pair_lo(p) + 1], mem[rf_pkg::pair_lo(p)]};
  end
  assign data = pairs[idx];
endmodule

// File: rtl/regfile_pair.sv
module regfile_pair #(
  parameter int NREG = 32,
  parameter int W    = 8,
  localparam int AW  = $clog2(NREG),
  localparam int PW  = AW - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            pw_en,
  input  logic [PW-1:0]   pw_idx,
  input  logic [2*W-1:0]  pw_data,
  input  logic [AW-1:0]   rda_addr,
  output logic [W-1:0]    rda_data,
  input  logic [AW-1:0]   rdb_addr,
  output logic [W-1:0]    rdb_data,
  input  logic [PW-1:0]   rp_idx,
  output logic [2*W-1:0]  rp_data
);
  logic [NREG-1:0][W-1:0] mem;
  logic [NREG-1:0]        we;
  logic [NREG-1:0][W-1:0] wd;

  rf_wr_decode #(.NREG(NREG), .W(W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
    .we(we), .wd(wd)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        mem[i] <= '0;
      else if (we[i]) mem[i] <= wd[i];
    end
  end

  rf_rd_mux #(.NREG(NREG), .W(W)) u_rda (.mem(mem), .addr(rda_addr), .data(rda_data));
  rf_rd_mux #(.NREG(NREG), .W(W)) u_rdb (.mem(mem), .addr(rdb_addr), .data(rdb_data));
  rf_pair_mux #(.NREG(NREG), .W(W)) u_rdp (.mem(mem), .idx(rp_idx), .data(rp_data));
endmodule

// File: rtl/regfile_pair_chk.sv
module regfile_pair_chk #(
  parameter int NREG = 32,
  parameter int W    = 8,
  localparam int AW  = $clog2(NREG),
  localparam int PW  = AW - 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [W-1:0]           wr_data,
  input logic                   pw_en,
  input logic [PW-1:0]          pw_idx,
  input logic [2*W-1:0]         pw_data,
  input logic [AW-1:0]          rda_addr,
  input logic [W-1:0]           rda_data,
  input logic [AW-1:0]          rdb_addr,
  input logic [W-1:0]           rdb_data,
  input logic [PW-1:0]          rp_idx,
  input logic [2*W-1:0]         rp_data,
  input logic [NREG-1:0][W-1:0] mem
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (mem == '0));

  p_read_ports_r2: assert property (@(posedge clk) disable iff (rst)
    (rda_data == mem[rda_addr]) && (rdb_data == mem[rdb_addr]));

  p_byte_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !pw_en) |=> (mem[$past(wr_addr)] == $past(wr_data)));

  p_pair_write_r5: assert property (@(posedge clk) disable iff (rst)
    pw_en |=> ({mem[{$past(pw_idx), 1'b1}], mem[{$past(pw_idx), 1'b0}]} == $past(pw_data)));

  p_pair_read_r6: assert property (@(posedge clk) disable iff (rst)
    rp_data == {mem[{rp_idx, 1'b1}], mem[{rp_idx, 1'b0}]});

  p_pair_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pw_en && (wr_addr[AW-1:1] == pw_idx)) |=>
      (mem[$past(wr_addr)] == ($past(wr_addr[0]) ? $past(pw_data[2*W-1:W]) : $past(pw_data[W-1:0]))));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !pw_en) |=> $stable(mem));
endmodule

bind regfile_pair regfile_pair_chk #(.NREG(NREG), .W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
  .rda_addr(rda_addr), .rda_data(rda_data), .rdb_addr(rdb_addr), .rdb_data(rdb_data),
  .rp_idx(rp_idx), .rp_data(rp_data), .mem(mem)
);

// File: tb/regfile_pair_tb.sv
module regfile_pair_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, wr_en, pw_en;
  logic [4:0] wr_addr, rda_addr, rdb_addr;
  logic [7:0] wr_data, rda_data, rdb_data;
  logic [3:0] pw_idx, rp_idx;
  logic [15:0] pw_data, rp_data;

  regfile_pair u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
    .rda_addr(rda_addr), .rda_data(rda_data), .rdb_addr(rdb_addr), .rdb_data(rdb_data),
    .rp_idx(rp_idx), .rp_data(rp_data)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [32];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference update from the requirement text; called at each rising edge.
  task automatic model_edge();
    if (rst) begin
      for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    end else begin
      if (wr_en && !(pw_en && wr_addr[4:1] == pw_idx)) mdl[wr_addr] = wr_data;
      if (pw_en) begin
        mdl[{pw_idx, 1'b0}] = pw_data[7:0];
        mdl[{pw_idx, 1'b1}] = pw_data[15:8];
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    rst = 0; wr_en = 0; pw_en = 0;
    wr_addr = 0; wr_data = 0; pw_idx = 0; pw_data = 0;
    rda_addr = 0; rdb_addr = 0; rp_idx = 0;
  endtask

  task automatic check_all_bytes(input string req);
    for (int i = 0; i < 32; i++) begin
      rda_addr = 5'(i); rdb_addr = 5'(31 - i); #1;
      chk(req, {8'h0, rda_data}, {8'h0, mdl[i]});
      chk(req, {8'h0, rdb_data}, {8'h0, mdl[31 - i]});
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 8'hxx;
    idle_inputs();
    rst = 1;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    check_all_bytes("R1");

    // Byte writes; the same-cycle read must show the old value.
    for (int i = 0; i < 32; i++) begin
      wr_en = 1; wr_addr = 5'(i); wr_data = 8'(i * 37 + 5);
      rda_addr = 5'(i); rdb_addr = 5'(i); #1;
      chk("R4", {8'h0, rda_data}, {8'h0, mdl[i]});
      chk("R4", {8'h0, rdb_data}, {8'h0, mdl[i]});
      tick();
      wr_en = 0; #1;
      chk("R3", {8'h0, rda_data}, {8'h0, 8'(i * 37 + 5)});
    end

    // Exhaustive two-port read sweep.
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++) begin
        rda_addr = 5'(a); rdb_addr = 5'(b); #1;
        chk("R2", {8'h0, rda_data}, {8'h0, mdl[a]});
        chk("R2", {8'h0, rdb_data}, {8'h0, mdl[b]});
      end

    for (int p = 0; p < 16; p++) begin
      rp_idx = 4'(p); #1;
      chk("R6", rp_data, {mdl[2*p+1], mdl[2*p]});
    end

    // Pair writes, with concurrent byte and pair reads of the target.
    for (int p = 0; p < 16; p++) begin
      pw_en = 1; pw_idx = 4'(p); pw_data = 16'(p * 4097 + 16'hA50F);
      rp_idx = 4'(p); rda_addr = 5'(2*p); rdb_addr = 5'(2*p+1); #1;
      chk("R7", rp_data, {mdl[2*p+1], mdl[2*p]});
      chk("R7", {8'h0, rda_data}, {8'h0, mdl[2*p]});
      tick();
      pw_en = 0; #1;
      chk("R5", {8'h0, rda_data}, {8'h0, pw_data[7:0]});
      chk("R5", {8'h0, rdb_data}, {8'h0, pw_data[15:8]});
      chk("R6", rp_data, pw_data);
    end

    // Collision inside the pair: pair wins on both bytes.
    wr_en = 1; wr_addr = 5'd7; wr_data = 8'h3C;
    pw_en = 1; pw_idx = 4'd3; pw_data = 16'hBEEF;
    tick();
    wr_en = 0; pw_en = 0; rp_idx = 4'd3; rda_addr = 5'd7; #1;
    chk("R8", rp_data, 16'hBEEF);
    chk("R8", {8'h0, rda_data}, 16'h00BE);
    // Collision outside the pair: both take effect.
    wr_en = 1; wr_addr = 5'd20; wr_data = 8'h5A;
    pw_en = 1; pw_idx = 4'd1; pw_data = 16'h1234;
    tick();
    wr_en = 0; pw_en = 0; rda_addr = 5'd20; rp_idx = 4'd1; #1;
    chk("R8", {8'h0, rda_data}, 16'h005A);
    chk("R8", rp_data, 16'h1234);

    // Idle edges with busy address/data lines.
    for (int k = 0; k < 4; k++) begin
      wr_addr = 5'(k * 9); wr_data = 8'hFF; pw_idx = 4'(k * 5); pw_data = 16'hFFFF;
      tick();
    end
    check_all_bytes("R9");

    // Late reset.
    rst = 1; tick(); rst = 0;
    check_all_bytes("R1");
    for (int p = 0; p < 16; p++) begin
      rp_idx = 4'(p); #1;
      chk("R1", rp_data, 16'h0000);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule